// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block sits between an in-order request queue and the command pins of an SDRAM device. Each cycle it looks at the request at the head of the queue. A read or write is turned into a command, or the block holds the request and emits NOP cycles until the command can legally go out. Its main job is the switch from a read burst to a write. The device keeps driving read words on the shared data bus for CAS-latency cycles after a READ. A WRITE that follows too soon would collide with them.

The block tracks the tail of the most recent read burst. When a write arrives, it picks the earliest WRITE cycle that still leaves one idle bus cycle after the last read word the device actually drives. There are two ways to reach that cycle. One is to wait for the read words to run out. The other is to raise the data mask early, which suppresses the remaining words (the device applies the mask to read data two cycles later). The block takes whichever path reaches the WRITE first. It also enables the controller's data drivers for the write burst, and it carries the request's byte mask through every write data cycle.

Requests use a valid/ready handshake. Ready is high only in the cycle the command issues, and a held request is never lost.

Top module: `sd_turn_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_o` is NOP (code 0), `dqm_o` is all zeros, `dq_oe_o` is 0 and `req_ready` is 0.
- R2: A read request (`req_write`=0) issues in the cycle it is presented, as long as no write burst is still being driven. In that cycle `req_ready`=1, `cmd_o`=READ (code 1) and `bank_o`/`col_o` equal the request. In every cycle without an issue, `cmd_o` is NOP.
- R3: Read requests presented on consecutive cycles issue on consecutive cycles, with no NOP between them.
- R4: A read issued at cycle r drives words in cycles r+CL .. r+CL+BL-1, where CL is 3 when `cas_lat`=3 and 2 otherwise, and BL=4. A write presented at r+1 issues at r+4. Each of the three cycles before it is a NOP with `dqm_o` all ones (a set bit masks its byte).
- R5: For a write first presented at cycle d after a read at r, let L=r+CL+BL-1. The WRITE issues at d when L <= d-2, and otherwise at min(L+2, d+3). When the wait ends by the read words running out, `dqm_o` stays zero during the wait.
- R6: The last read word left unmasked before a WRITE at cycle w falls no later than w-2, so the bus is idle in cycle w-1. A read word is masked when `dqm_o` was all ones two cycles before it.
- R7: `dq_oe_o` is high for exactly BL cycles starting at the WRITE cycle, and is low in the cycle just before it.
- R8: In each write data cycle, `dqm_o` equals the byte mask `req_wmask` that was presented with that write.
- R9: Write requests on consecutive cycles issue on consecutive cycles. `dq_oe_o` stays high from the first WRITE through BL-1 cycles past the last.
- R10: A read that follows a write issues no earlier than BL cycles after the WRITE, and never in a cycle where `dq_oe_o` is high.
- R11: A request that cannot issue is held with NOPs and is accepted in the first legal cycle. It is neither dropped nor issued twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | 2 | CAS latency setting (3 selects 3, any other value 2) |
| req_valid | input | 1 | Head-of-queue request present |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_bank | input | BANK_W | Request bank |
| req_col | input | COL_W | Request column |
| req_wmask | input | DQM_W | Write byte mask (1 = byte masked) |
| req_ready | output | 1 | Request accepted this cycle |
| cmd_o | output | 2 | Command: 0 NOP, 1 READ, 2 WRITE |
| bank_o | output | BANK_W | Bank of issued command, zero otherwise |
| col_o | output | COL_W | Column of issued command, zero otherwise |
| dqm_o | output | DQM_W | Data mask pins |
| dq_oe_o | output | 1 | Controller data-bus drive enable |

## Verification
The bench sends a write immediately after a read with both CAS latencies. This exercises the early-mask path and shows whether the mask lead and the idle gap are placed correctly. It then sends writes after idle gaps of several lengths, which land the request just inside and just outside the window where the read tail still matters. Those cases tell the natural wait apart from the masked one and locate the boundary at L = d-2. Runs of back-to-back reads and writes show that no turnaround is inserted where none is needed. A read that follows a write shows that the drive window blocks the read and that the held request is kept.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } sdt_cmd_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_MASK = 1'b1
  } sdt_state_e;

  // DQM acts on read data two cycles later, plus one idle cycle.
  localparam int unsigned MASK_LEAD = 3;

  function automatic int unsigned eff_cl(input logic [1:0] cl);
    return (cl == 2'd3) ? 3 : 2;
  endfunction

  // Tail count loaded at read issue: cycles until last word + 2.
  function automatic int unsigned rd_tail_load(input logic [1:0] cl,
                                               input int unsigned bl);
    return eff_cl(cl) + bl;
  endfunction

endpackage

// File: rtl/sdt_rd_tail.sv
module sdt_rd_tail
  import sdt_pkg::*;
#(
  parameter int unsigned BL    = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cas_lat,
  input  logic       rd_issue,
  input  logic       wr_issue,
  output logic       rd_quiet,
  output logic       rd_far
);

  logic [CNT_W-1:0] cnt_q;

  // cnt_q = last_read_word_cycle - now + 2, saturating at zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (rd_issue)         cnt_q <= CNT_W'(rd_tail_load(cas_lat, BL));
    else if (wr_issue)         cnt_q <= '0;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign rd_quiet = (cnt_q == '0);
  assign rd_far   = (cnt_q > CNT_W'(MASK_LEAD));

endmodule

// File: rtl/sdt_wr_drive.sv
module sdt_wr_drive #(
  parameter int unsigned BL    = 4,
  parameter int unsigned DQM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_issue,
  input  logic [DQM_W-1:0] wmask_in,
  output logic             drive_oe,
  output logic             wr_tail,
  output logic [DQM_W-1:0] wmask_q
);

  localparam int unsigned WC_W = (BL > 2) ? $clog2(BL) : 1;

  logic [WC_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      wmask_q <= '0;
    end else if (wr_issue) begin
      cnt_q   <= WC_W'(BL - 1);
      wmask_q <= wmask_in;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end

  assign wr_tail  = (cnt_q != '0);
  assign drive_oe = wr_issue | wr_tail;

endmodule

// File: rtl/sdt_turn_fsm.sv
module sdt_turn_fsm
  import sdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic rd_quiet,
  input  logic rd_far,
  input  logic wr_busy,
  output logic issue_rd,
  output logic issue_wr,
  output logic mask_phase
);

  localparam int unsigned MC_W = $clog2(MASK_LEAD + 1);

  sdt_state_e      st_q;
  logic [MC_W-1:0] mcnt_q;
  logic            head_rd, head_wr, mask_start, mask_done;

  always_comb begin
    head_rd    = req_valid & ~req_write;
    head_wr    = req_valid & req_write;
    mask_start = (st_q == ST_RUN) && head_wr && rd_far;
    mask_done  = (st_q == ST_MASK) && (mcnt_q == MC_W'(MASK_LEAD));
    issue_rd   = (st_q == ST_RUN) && head_rd && !wr_busy;
    issue_wr   = head_wr && (((st_q == ST_RUN) && rd_quiet) || mask_done);
    mask_phase = mask_start || ((st_q == ST_MASK) && !mask_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      mcnt_q <= '0;
    end else if (st_q == ST_RUN) begin
      if (mask_start) begin
        st_q   <= ST_MASK;
        mcnt_q <= MC_W'(1);
      end
    end else if (issue_wr) begin
      st_q   <= ST_RUN;
      mcnt_q <= '0;
    end else if (!mask_done) begin
      mcnt_q <= mcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sd_turn_sched.sv
module sd_turn_sched
  import sdt_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned DQM_W  = 2,
  parameter int unsigned BL     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cas_lat,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DQM_W-1:0]  req_wmask,
  output logic              req_ready,
  output logic [1:0]        cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic [DQM_W-1:0]  dqm_o,
  output logic              dq_oe_o
);

  localparam int unsigned CNT_W = $clog2(BL + 4);

  logic             issue_rd, issue_wr, mask_phase;
  logic             rd_quiet, rd_far;
  logic             wr_tail, drive_oe;
  logic [DQM_W-1:0] wmask_q;

  sdt_rd_tail #(.BL(BL), .CNT_W(CNT_W)) u_rd_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_lat  (cas_lat),
    .rd_issue (issue_rd),
    .wr_issue (issue_wr),
    .rd_quiet (rd_quiet),
    .rd_far   (rd_far)
  );

  sdt_wr_drive #(.BL(BL), .DQM_W(DQM_W)) u_wr_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_issue (issue_wr),
    .wmask_in (req_wmask),
    .drive_oe (drive_oe),
    .wr_tail  (wr_tail),
    .wmask_q  (wmask_q)
  );

  sdt_turn_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .rd_quiet   (rd_quiet),
    .rd_far     (rd_far),
    .wr_busy    (wr_tail),
    .issue_rd   (issue_rd),
    .issue_wr   (issue_wr),
    .mask_phase (mask_phase)
  );

  assign req_ready = issue_rd | issue_wr;
  assign cmd_o     = issue_rd ? CMD_READ : (issue_wr ? CMD_WRITE : CMD_NOP);
  assign bank_o    = req_ready ? req_bank : '0;
  assign col_o     = req_ready ? req_col  : '0;
  assign dq_oe_o   = drive_oe;

  for (genvar i = 0; i < DQM_W; i++) begin : g_lane
    assign dqm_o[i] = mask_phase |
                      (issue_wr ? req_wmask[i] : (wr_tail & wmask_q[i]));
  end

endmodule

// File: rtl/sd_turn_chk.sv
module sd_turn_chk
  import sdt_pkg::*;
#(
  parameter int unsigned DQM_W = 2,
  parameter int unsigned BL    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cas_lat,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       cmd_o,
  input logic [DQM_W-1:0] dqm_o,
  input logic             dq_oe_o,
  input logic             mask_phase
);

  localparam int PW = int'(BL) + 4;

  logic [PW-1:0]    pend_q, pend_nx;
  logic [DQM_W-1:0] d1_q, d2_q;
  logic             word_now;
  int               cl_i;

  always_comb begin
    cl_i    = (cas_lat == 2'd3) ? 3 : 2;
    pend_nx = pend_q >> 1;
    if (cmd_o == CMD_WRITE) begin
      pend_nx = '0;
    end else if (cmd_o == CMD_READ) begin
      for (int i = 0; i < PW; i++) begin
        if (i >= cl_i - 1) pend_nx[i] = (i <= cl_i + int'(BL) - 2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
    end else begin
      pend_q <= pend_nx;
      d1_q   <= dqm_o;
      d2_q   <= d1_q;
    end
  end

  assign word_now = pend_q[0] && (d2_q != '1) && (cmd_o != CMD_WRITE);

  AST_BUS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_WRITE) |-> !$past(word_now)); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> !word_now); // R6
  AST_MASK_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o == CMD_WRITE) && $past(mask_phase)) |->
      (($past(dqm_o, 1) == '1) && ($past(dqm_o, 2) == '1))); // R4
  AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe_o) |-> (cmd_o == CMD_WRITE)); // R7
  AST_RD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_READ) |-> !dq_oe_o); // R10
  AST_READY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid); // R11
  AST_CMD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != CMD_NOP) |-> req_ready); // R2

endmodule

bind sd_turn_sched sd_turn_chk #(.DQM_W(DQM_W), .BL(BL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cas_lat    (cas_lat),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .cmd_o      (cmd_o),
  .dqm_o      (dqm_o),
  .dq_oe_o    (dq_oe_o),
  .mask_phase (mask_phase)
);

// File: tb/sd_turn_sched_test.sv
`timescale 1ns/1ps
module sd_turn_sched_test;

  localparam int BL = 4;
  localparam int LOGN = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cas_lat = 2'd2;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [9:0] req_col = '0;
  logic [1:0] req_wmask = '0;
  logic       req_ready;
  logic [1:0] cmd_o;
  logic [1:0] bank_o;
  logic [9:0] col_o;
  logic [1:0] dqm_o;
  logic       dq_oe_o;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int log_cmd [LOGN];
  int log_dqm [LOGN];
  int log_oe  [LOGN];
  int log_col [LOGN];
  int log_bank[LOGN];

  sd_turn_sched uut (
    .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
    .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
    .req_col(req_col), .req_wmask(req_wmask), .req_ready(req_ready),
    .cmd_o(cmd_o), .bank_o(bank_o), .col_o(col_o),
    .dqm_o(dqm_o), .dq_oe_o(dq_oe_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cyc < LOGN) begin
      log_cmd[cyc]  = int'(cmd_o);
      log_dqm[cyc]  = int'(dqm_o);
      log_oe[cyc]   = int'(dq_oe_o);
      log_col[cyc]  = int'(col_o);
      log_bank[cyc] = int'(bank_o);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input bit wr, input logic [1:0] bk, input logic [9:0] col,
                      input logic [1:0] m, output int at);
    req_valid = 1'b1;
    req_write = wr;
    req_bank  = bk;
    req_col   = col;
    req_wmask = m;
    at = -1;
    while (at < 0) begin
      @(negedge clk);
      if (req_ready) at = cyc;
    end
    @(posedge clk);
    #1;
  endtask

  // Last read word left unmasked before cycle w for a read at r.
  function automatic int last_driven(input int r, input int cl, input int w);
    int last = -1;
    for (int c = r + cl; c < r + cl + BL; c++)
      if (c < w && log_dqm[c-2] != 3) last = c;
    return last;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cmd in reset", log_cmd[cyc], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd", int'(cmd_o), 0);
    chk("R1 dqm", int'(dqm_o), 0);
    chk("R1 oe", int'(dq_oe_o), 0);
    chk("R1 ready", int'(req_ready), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_reads();
    int a, b, c;
    cas_lat = 2'd2;
    idle(10);
    send(1'b0, 2'd3, 10'h123, 2'b00, a);
    send(1'b0, 2'd1, 10'h045, 2'b00, b);
    send(1'b0, 2'd2, 10'h300, 2'b00, c);
    idle(10);
    chk("R3 second read", b, a + 1);
    chk("R3 third read", c, b + 1);
    chk("R2 read cmd", log_cmd[a], 1);
    chk("R2 read bank", log_bank[a], 3);
    chk("R2 read col", log_col[a], 'h123);
    chk("R2 idle nop", log_cmd[a-1], 0);
  endtask

  task automatic t_rd_wr(input int cl);
    int r, w;
    cas_lat = 2'(cl);
    idle(10);
    send(1'b0, 2'd1, 10'h155, 2'b00, r);
    send(1'b1, 2'd2, 10'h0AA, 2'b01, w);
    idle(12);
    chk($sformatf("R4 write cycle cl%0d", cl), w - r, 4);
    for (int k = 1; k <= 3; k++) begin
      chk("R4 mask lead dqm", log_dqm[w-k], 3);
      chk("R4 mask lead nop", log_cmd[w-k], 0);
    end
    chk("R4 dqm at read", log_dqm[r], 0);
    chk("R2 write cmd/col", log_cmd[w] * 1024 + log_col[w], 2 * 1024 + 'hAA);
    chk("R6 gap", int'(last_driven(r, cl, w) <= w - 2), 1);
    chk("R7 oe before", log_oe[w-1], 0);
    for (int k = 0; k < BL; k++) begin
      chk("R7 oe window", log_oe[w+k], 1);
      chk("R8 write mask", log_dqm[w+k], 1);
    end
    chk("R7 oe after", log_oe[w+BL], 0);
  endtask

  task automatic t_natural(input int cl, input int gap);
    int r, w, d, l, exp;
    cas_lat = 2'(cl);
    idle(10);
    send(1'b0, 2'd0, 10'h010, 2'b00, r);
    idle(gap);
    d = r + 1 + gap;
    send(1'b1, 2'd0, 10'h020, 2'b00, w);
    idle(12);
    l = r + cl + BL - 1;
    if (l <= d - 2) exp = d;
    else exp = (l + 2 < d + 3) ? l + 2 : d + 3;
    chk($sformatf("R5 write cycle cl%0d gap%0d", cl, gap), w, exp);
    for (int c = d; c < w; c++) begin
      chk("R5 dqm low while waiting", log_dqm[c], 0);
      chk("R11 held nop", log_cmd[c], 0);
    end
    chk("R6 gap natural", int'(last_driven(r, cl, w) <= w - 2), 1);
  endtask

  task automatic t_wrs();
    int w1, w2, w3;
    idle(10);
    send(1'b1, 2'd0, 10'h001, 2'b00, w1);
    send(1'b1, 2'd1, 10'h002, 2'b10, w2);
    send(1'b1, 2'd2, 10'h003, 2'b11, w3);
    idle(10);
    chk("R9 second write", w2, w1 + 1);
    chk("R9 third write", w3, w2 + 1);
    for (int c = w1; c < w3 + BL; c++) chk("R9 oe continuous", log_oe[c], 1);
    chk("R7 oe end", log_oe[w3+BL], 0);
    chk("R8 mask w1", log_dqm[w1], 0);
    chk("R8 mask w2", log_dqm[w2], 2);
    chk("R8 mask held", log_dqm[w3+2], 3);
  endtask

  task automatic t_wr_rd();
    int w, r;
    cas_lat = 2'd3;
    idle(10);
    send(1'b1, 2'd1, 10'h0F0, 2'b00, w);
    send(1'b0, 2'd1, 10'h0F4, 2'b00, r);
    idle(10);
    chk("R10 read after write", r - w, BL);
    chk("R10 oe at read", log_oe[r], 0);
    for (int c = w + 1; c < r; c++) chk("R11 held read nop", log_cmd[c], 0);
    chk("R11 read once", log_cmd[r] * 1024 + log_col[r], 1 * 1024 + 'hF4);
    chk("R11 no duplicate", log_cmd[r+1], 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 5000);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_reads();
    t_rd_wr(2);
    t_rd_wr(3);
    t_natural(3, 5);
    t_natural(2, 6);
    t_natural(2, 4);
    t_wrs();
    t_wr_rd();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule